// File: doc/BRIEF.md
# Multiplexed General-Purpose I/O Port

This block is one register-mapped general-purpose I/O port of eight pins. A small synchronous register bus with address, write strobe, read strobe, write data and read data gives access to four registers: the port output data, the per-pin direction, the per-pin peripheral select, and the function-extension select. On the pad side it drives an output value and an output enable for each pin. It also takes the raw pin level, which passes through a two-flop synchronizer before any use.

Each pin is served by one of three sources. The plain port data path is the default. The peripheral-circuit path uses the direction bit to set which way the signal flows. The extended-function path has its own output value and output enable. A function-extension bit overrides the other two, and one such bit may own a group of pins. The block has two synchronous active-low resets. A cold start clears the registers to their power-up values. A hot start keeps every register and clears only the synchronizer and the read-data flop. If both resets are low, cold start wins.

Top module: `gpio_mux_port`

## Requirements
- R1: A write to the data register (address 0) is stored even while the pin's direction bit is 0. When the direction bit later becomes 1 on the port path, the stored value appears on `pin_out` with no further data write.
- R2: A read of address 0 returns the synchronized pin level for every bit, 1 for high and 0 for low, whatever the direction bit and pin selection.
- R3: On the port path, direction bit p (address 1) set to 1 gives `pin_oe[p]`=1 and `pin_out[p]` = data bit p, and set to 0 gives `pin_oe[p]`=0. The direction register reads back the value written at the edge after the write strobe.
- R4: After a cold start the data, direction and peripheral-select registers read 0 and the function-extension register (address 3) reads 8'h03.
- R5: While a hot start is held, all four registers keep their values and bus writes are ignored. `bus_rdata` is 0 during the reset.
- R6: With both resets low together, the cold-start values of R4 result.
- R7: Function-extension bit 0 owns pins 0 and 1, bit 1 owns pins 2, 3 and 4, and bits 2, 3 and 4 own pins 5, 6 and 7. Bits 5 to 7 own no pin but are stored and read back. An owned pin with its bit at 1 drives `ext_out[p]` and `ext_oe[p]`.
- R8: Selection priority is function extension, then peripheral select (address 2, bit p = 1), then port data. On the peripheral path `pin_out[p]` = `per_out[p]` and `pin_oe[p]` = direction bit p.
- R9: `per_in[p]` equals the synchronized pin level when pin p is on the peripheral path with direction 0, and is otherwise 0. `ext_in[p]` equals it when pin p is on the extended path, and is otherwise 0. A pin change shows there two clock edges after it is sampled.
- R10: `bus_rdata` is registered and valid the cycle after `bus_rd`. It is 0 for addresses 4 to 7 and in any cycle that follows no read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_cold_n | input | 1 | Synchronous active-low cold start, clears registers |
| rst_hot_n | input | 1 | Synchronous active-low hot start, registers kept |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pin_in | input | 8 | Raw pin level from the pads |
| pin_out | output | 8 | Value driven to the pads |
| pin_oe | output | 8 | Output enable to the pads |
| per_out | input | 8 | Peripheral-circuit output values |
| per_in | output | 8 | Synchronized pin level to the peripheral circuits |
| ext_out | input | 8 | Extended-function output values |
| ext_oe | input | 8 | Extended-function output enables |
| ext_in | output | 8 | Synchronized pin level to the extended functions |

## Verification
The pin selection is exercised with register settings that put every pin on the port path, every pin on the peripheral path with mixed directions, and single function-extension bits. Each such bit covers a different pin group, and bits owning no pin are set as well, so a wrong group mapping or a broken priority order shows up on particular pins. The peripheral, extended and pin-input vectors differ from one another in each pattern, so a pin that takes its value from the wrong source is caught. Directed sequences then separate cold start from hot start, check that a hot start ignores writes, and check that a data value loaded while the pin is an input appears once the direction changes.

// File: rtl/gpio_mux_pkg.sv
// Shared definitions for the multiplexed GPIO port.
// Assumes a register bus of at most eight addresses; the group map below
// is fixed by the pin-group wiring of the port.
package gpio_mux_pkg;

    localparam int ADDR_W_DEF = 3;

    // Register offsets on the bus
    localparam int A_DATA = 0;
    localparam int A_DIR  = 1;
    localparam int A_PSEL = 2;
    localparam int A_FX   = 3;

    // Source that serves one pin
    typedef enum logic [1:0] {
        PATH_PORT   = 2'd0,
        PATH_PERIPH = 2'd1,
        PATH_EXT    = 2'd2
    } pin_path_e;

    // Function-extension bit that owns a given pin
    function automatic int fx_owner(input int pin, input int fx_w);
        if (pin < 2) return 0;
        if (pin < 5) return 1;
        return (pin - 3) % fx_w;
    endfunction

endpackage

// File: rtl/gpio_mux_regs.sv
// Register file of the GPIO port: data, direction, peripheral select and
// function-extension select. Cold start loads power-up values; hot start
// keeps every bit and blocks writes. Assumes synchronous active-low resets.
module gpio_mux_regs #(
    parameter int WIDTH  = 8,
    parameter int FX_W   = 8,
    parameter int ADDR_W = 3,
    parameter int BUS_W  = 8,
    parameter logic [FX_W-1:0] FX_COLD = 8'h03
) (
    input  logic              clk,
    input  logic              rst_cold_n,
    input  logic              rst_hot_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BUS_W-1:0]  wdata,
    output logic [WIDTH-1:0]  data_q,
    output logic [WIDTH-1:0]  dir_q,
    output logic [WIDTH-1:0]  psel_q,
    output logic [FX_W-1:0]   fx_q
);
    import gpio_mux_pkg::*;

    logic wr_ok;
    logic hit_data, hit_dir, hit_psel, hit_fx;

    // Writes are accepted only outside both resets
    always_comb begin
        wr_ok    = wr_en && rst_hot_n;
        hit_data = wr_ok && (addr == ADDR_W'(A_DATA));
        hit_dir  = wr_ok && (addr == ADDR_W'(A_DIR));
        hit_psel = wr_ok && (addr == ADDR_W'(A_PSEL));
        hit_fx   = wr_ok && (addr == ADDR_W'(A_FX));
    end

    // Port output data, accepted whatever the direction
    always_ff @(posedge clk) begin
        if (!rst_cold_n)   data_q <= '0;
        else if (hit_data) data_q <= wdata[WIDTH-1:0];
    end

    // Direction, 1 = drive
    always_ff @(posedge clk) begin
        if (!rst_cold_n)  dir_q <= '0;
        else if (hit_dir) dir_q <= wdata[WIDTH-1:0];
    end

    // Peripheral-path select
    always_ff @(posedge clk) begin
        if (!rst_cold_n)   psel_q <= '0;
        else if (hit_psel) psel_q <= wdata[WIDTH-1:0];
    end

    // Function-extension select with non-zero cold value
    always_ff @(posedge clk) begin
        if (!rst_cold_n) fx_q <= FX_COLD;
        else if (hit_fx) fx_q <= wdata[FX_W-1:0];
    end

endmodule

// File: rtl/gpio_mux_sync.sv
// Multi-stage synchronizer for the raw pin levels. Every bit is treated as
// independent; no bus coherence is assumed. Cleared by either reset.
module gpio_mux_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] q_out
);
    logic [WIDTH-1:0] chain [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // First capture stage
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[0] <= '0;
                    else        chain[0] <= d_in;
                end
            end else begin : g_next
                // Following settling stage
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[s] <= '0;
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q_out = chain[STAGES-1];

endmodule

// File: rtl/gpio_mux_pinmux.sv
// Per-pin source selection. Priority: extended function, then peripheral,
// then port data. Input forwarding follows the same choice. Purely
// combinational; assumes the pin level is already synchronized.
module gpio_mux_pinmux #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] fx_pin,
    input  logic [WIDTH-1:0] psel_q,
    input  logic [WIDTH-1:0] dir_q,
    input  logic [WIDTH-1:0] data_q,
    input  logic [WIDTH-1:0] per_out,
    input  logic [WIDTH-1:0] ext_out,
    input  logic [WIDTH-1:0] ext_oe,
    input  logic [WIDTH-1:0] lvl,
    output logic [WIDTH-1:0] pin_out,
    output logic [WIDTH-1:0] pin_oe,
    output logic [WIDTH-1:0] per_in,
    output logic [WIDTH-1:0] ext_in
);
    import gpio_mux_pkg::*;

    genvar p;
    generate
        for (p = 0; p < WIDTH; p++) begin : g_pin
            pin_path_e path;

            // Pick the source serving this pin
            always_comb begin
                if (fx_pin[p])      path = PATH_EXT;
                else if (psel_q[p]) path = PATH_PERIPH;
                else                path = PATH_PORT;
            end

            // Drive value and enable from the chosen source
            always_comb begin
                unique case (path)
                    PATH_EXT: begin
                        pin_out[p] = ext_out[p];
                        pin_oe[p]  = ext_oe[p];
                    end
                    PATH_PERIPH: begin
                        pin_out[p] = per_out[p];
                        pin_oe[p]  = dir_q[p];
                    end
                    default: begin
                        pin_out[p] = data_q[p];
                        pin_oe[p]  = dir_q[p];
                    end
                endcase
            end

            // Forward the level only to the source that owns the pin
            always_comb begin
                ext_in[p] = (path == PATH_EXT) & lvl[p];
                per_in[p] = (path == PATH_PERIPH) & ~dir_q[p] & lvl[p];
            end
        end
    endgenerate

endmodule

// File: rtl/gpio_mux_rdport.sv
// Registered read path. Address 0 returns the synchronized pin level,
// not the stored data. Unmapped addresses and idle cycles give zero.
module gpio_mux_rdport #(
    parameter int WIDTH  = 8,
    parameter int FX_W   = 8,
    parameter int ADDR_W = 3,
    parameter int BUS_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WIDTH-1:0]  lvl,
    input  logic [WIDTH-1:0]  dir_q,
    input  logic [WIDTH-1:0]  psel_q,
    input  logic [FX_W-1:0]   fx_q,
    output logic [BUS_W-1:0]  rdata
);
    import gpio_mux_pkg::*;

    logic [BUS_W-1:0] rd_mux;

    // Address decode of the readable values
    always_comb begin
        rd_mux = '0;
        if (addr == ADDR_W'(A_DATA))      rd_mux = BUS_W'(lvl);
        else if (addr == ADDR_W'(A_DIR))  rd_mux = BUS_W'(dir_q);
        else if (addr == ADDR_W'(A_PSEL)) rd_mux = BUS_W'(psel_q);
        else if (addr == ADDR_W'(A_FX))   rd_mux = BUS_W'(fx_q);
    end

    // Capture on a read strobe, zero otherwise
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= rd_mux;
        else            rdata <= '0;
    end

endmodule

// File: rtl/gpio_mux_port.sv
// Top of the multiplexed GPIO port. Wires the register file, the pin
// synchronizer, the per-pin selector and the read path. Assumes both
// resets are synchronous to clk; cold start dominates hot start.
module gpio_mux_port #(
    parameter int WIDTH       = 8,
    parameter int FX_W        = 8,
    parameter int ADDR_W      = gpio_mux_pkg::ADDR_W_DEF,
    parameter int SYNC_STAGES = 2,
    parameter logic [FX_W-1:0] FX_COLD = 8'h03,
    localparam int BUS_W = (WIDTH > FX_W) ? WIDTH : FX_W
) (
    input  logic              clk,
    input  logic              rst_cold_n,
    input  logic              rst_hot_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic [WIDTH-1:0]  pin_in,
    output logic [WIDTH-1:0]  pin_out,
    output logic [WIDTH-1:0]  pin_oe,
    input  logic [WIDTH-1:0]  per_out,
    output logic [WIDTH-1:0]  per_in,
    input  logic [WIDTH-1:0]  ext_out,
    input  logic [WIDTH-1:0]  ext_oe,
    output logic [WIDTH-1:0]  ext_in
);
    logic [WIDTH-1:0] data_q, dir_q, psel_q, lvl, fx_pin;
    logic [FX_W-1:0]  fx_q;
    logic             any_rst_n;

    assign any_rst_n = rst_cold_n & rst_hot_n;

    gpio_mux_regs #(
        .WIDTH(WIDTH), .FX_W(FX_W), .ADDR_W(ADDR_W), .BUS_W(BUS_W),
        .FX_COLD(FX_COLD)
    ) regs_i (
        .clk(clk), .rst_cold_n(rst_cold_n), .rst_hot_n(rst_hot_n),
        .wr_en(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
        .data_q(data_q), .dir_q(dir_q), .psel_q(psel_q), .fx_q(fx_q)
    );

    gpio_mux_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(any_rst_n), .d_in(pin_in), .q_out(lvl)
    );

    // Spread each function-extension bit over the pins it owns
    genvar p;
    generate
        for (p = 0; p < WIDTH; p++) begin : g_own
            assign fx_pin[p] = fx_q[gpio_mux_pkg::fx_owner(p, FX_W)];
        end
    endgenerate

    gpio_mux_pinmux #(.WIDTH(WIDTH)) mux_i (
        .fx_pin(fx_pin), .psel_q(psel_q), .dir_q(dir_q), .data_q(data_q),
        .per_out(per_out), .ext_out(ext_out), .ext_oe(ext_oe), .lvl(lvl),
        .pin_out(pin_out), .pin_oe(pin_oe), .per_in(per_in), .ext_in(ext_in)
    );

    gpio_mux_rdport #(
        .WIDTH(WIDTH), .FX_W(FX_W), .ADDR_W(ADDR_W), .BUS_W(BUS_W)
    ) rd_i (
        .clk(clk), .rst_n(any_rst_n), .rd_en(bus_rd), .addr(bus_addr),
        .lvl(lvl), .dir_q(dir_q), .psel_q(psel_q), .fx_q(fx_q),
        .rdata(bus_rdata)
    );

endmodule

// File: rtl/gpio_mux_port_chk.sv
// Property checker for the multiplexed GPIO port, bound to the top.
module gpio_mux_port_chk #(
    parameter int WIDTH  = 8,
    parameter int FX_W   = 8,
    parameter int ADDR_W = 3,
    parameter int BUS_W  = 8,
    parameter logic [FX_W-1:0] FX_COLD = 8'h03
) (
    input logic              clk,
    input logic              rst_cold_n,
    input logic              rst_hot_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [BUS_W-1:0]  bus_wdata,
    input logic [BUS_W-1:0]  bus_rdata,
    input logic [WIDTH-1:0]  data_q,
    input logic [WIDTH-1:0]  dir_q,
    input logic [WIDTH-1:0]  psel_q,
    input logic [FX_W-1:0]   fx_q,
    input logic [WIDTH-1:0]  per_in,
    input logic [WIDTH-1:0]  ext_in
);
    // R4
    cold_clear_chk: assert property (@(posedge clk) disable iff (!rst_hot_n)
        !rst_cold_n |=> (data_q == '0) && (dir_q == '0) && (psel_q == '0)
                        && (fx_q == FX_COLD));

    // R5
    hot_keep_chk: assert property (@(posedge clk) disable iff (!rst_cold_n)
        !rst_hot_n |=> $stable(data_q) && $stable(dir_q) && $stable(psel_q)
                       && $stable(fx_q));

    // R3
    dir_write_chk: assert property (@(posedge clk) disable iff (!rst_cold_n)
        (rst_hot_n && bus_wr && bus_addr == ADDR_W'(1))
            |=> dir_q == $past(bus_wdata[WIDTH-1:0]));

    // R10
    unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_cold_n)
        (bus_rd && bus_addr >= ADDR_W'(4)) |=> bus_rdata == '0);

    // R10
    idle_read_chk: assert property (@(posedge clk) disable iff (!rst_cold_n)
        !bus_rd |=> bus_rdata == '0);

    // R9
    fwd_excl_chk: assert property (@(posedge clk) disable iff (!rst_cold_n)
        (per_in & ext_in) == '0);

endmodule

bind gpio_mux_port gpio_mux_port_chk #(
    .WIDTH(WIDTH), .FX_W(FX_W), .ADDR_W(ADDR_W), .BUS_W(BUS_W),
    .FX_COLD(FX_COLD)
) chk_i (
    .clk(clk), .rst_cold_n(rst_cold_n), .rst_hot_n(rst_hot_n),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .data_q(data_q), .dir_q(dir_q), .psel_q(psel_q), .fx_q(fx_q),
    .per_in(per_in), .ext_in(ext_in)
);

// File: tb/gpio_mux_port_tb_top.sv
// Self-checking bench for the multiplexed GPIO port.
module gpio_mux_port_tb_top;

    logic       clk = 1'b0;
    logic       rst_cold_n = 1'b0;
    logic       rst_hot_n = 1'b1;
    logic [2:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] pin_in = '0, pin_out, pin_oe;
    logic [7:0] per_out = '0, per_in;
    logic [7:0] ext_out = '0, ext_oe = '0, ext_in;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    gpio_mux_port dut_i (
        .clk(clk), .rst_cold_n(rst_cold_n), .rst_hot_n(rst_hot_n),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .per_out(per_out), .per_in(per_in),
        .ext_out(ext_out), .ext_oe(ext_oe), .ext_in(ext_in)
    );

    // Vector: fx, psel, dir, data, per_out, ext_out, ext_oe, pin
    localparam logic [63:0] VEC [6] = '{
        64'h00_00_FF_A5_3C_0F_F0_5A,
        64'h00_FF_0F_A5_3C_55_AA_C3,
        64'h01_00_FF_5A_00_FF_00_0F,
        64'h02_F0_33_81_7E_AA_FF_FF,
        64'hE0_0F_FF_11_22_FF_FF_00,
        64'h1C_55_F0_96_69_C3_3C_A5
    };

    function automatic void check(string req, string what,
                                  logic [7:0] got, logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endfunction

    // Pins owned by a function-extension register value (R7 grouping)
    function automatic logic [7:0] ext_pins(logic [7:0] fx);
        return {fx[4], fx[3], fx[2], fx[1], fx[1], fx[1], fx[0], fx[0]};
    endfunction

    task automatic bus_write(logic [2:0] a, logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic settle();
        repeat (2) @(posedge clk);
        @(negedge clk);
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] rv;
        repeat (3) @(negedge clk);
        rst_cold_n = 1'b1;

        // R4: cold start values
        bus_read(3'd1, rv); check("R4", "dir after cold", rv, 8'h00);
        bus_read(3'd2, rv); check("R4", "psel after cold", rv, 8'h00);
        bus_read(3'd3, rv); check("R4", "fx after cold", rv, 8'h03);
        check("R4", "oe after cold", pin_oe, 8'h00);

        // Table of selection patterns (R7, R8, R9, R2)
        for (int i = 0; i < 6; i++) begin
            logic [7:0] fx, ps, dr, dt, po, xo, xe, pn, xp, pp;
            logic [7:0] e_out, e_oe, e_per, e_ext;
            {fx, ps, dr, dt, po, xo, xe, pn} = VEC[i];
            bus_write(3'd3, fx);
            bus_write(3'd2, ps);
            bus_write(3'd1, dr);
            bus_write(3'd0, dt);
            per_out = po; ext_out = xo; ext_oe = xe; pin_in = pn;
            settle();
            xp = ext_pins(fx);
            pp = ps & ~xp;
            e_out = (xp & xo) | (pp & po) | (~xp & ~ps & dt);
            e_oe  = (xp & xe) | (~xp & dr);
            e_per = pp & ~dr & pn;
            e_ext = xp & pn;
            check("R8", $sformatf("pin_out v%0d", i), pin_out, e_out);
            check("R8", $sformatf("pin_oe v%0d", i), pin_oe, e_oe);
            check("R9", $sformatf("per_in v%0d", i), per_in, e_per);
            check("R7", $sformatf("ext_in v%0d", i), ext_in, e_ext);
            bus_read(3'd0, rv);
            check("R2", $sformatf("pin read v%0d", i), rv, pn);
        end

        // R7: unowned fx bits are stored and read back
        bus_write(3'd3, 8'hE0);
        bus_read(3'd3, rv); check("R7", "fx readback", rv, 8'hE0);

        // R1: preload while input, then turn to output
        bus_write(3'd3, 8'h00);
        bus_write(3'd2, 8'h00);
        bus_write(3'd1, 8'h00);
        bus_write(3'd0, 8'h69);
        check("R1", "oe while input", pin_oe, 8'h00);
        bus_write(3'd1, 8'hFF);
        check("R1", "preloaded out", pin_out, 8'h69);
        check("R3", "oe after dir", pin_oe, 8'hFF);

        // R2: read returns pin level, not stored data, while driving
        pin_in = 8'h0F;
        settle();
        bus_read(3'd0, rv); check("R2", "pin read as output", rv, 8'h0F);

        // R9: two-edge latency of pin level to ext_in
        bus_write(3'd3, 8'h01);
        pin_in = 8'h00;
        settle();
        @(negedge clk);
        pin_in = 8'h03;
        @(posedge clk); @(negedge clk);
        check("R9", "ext_in after one edge", ext_in, 8'h00);
        @(posedge clk); @(negedge clk);
        check("R9", "ext_in after two edges", ext_in, 8'h03);

        // R10: unmapped address reads zero
        bus_read(3'd5, rv); check("R10", "unmapped read", rv, 8'h00);
        bus_read(3'd7, rv); check("R10", "unmapped read 7", rv, 8'h00);

        // R5: hot start keeps registers and ignores writes
        bus_write(3'd1, 8'hA5);
        bus_write(3'd3, 8'h5C);
        @(negedge clk);
        rst_hot_n = 1'b0;
        bus_addr = 3'd1; bus_wdata = 8'h3C; bus_wr = 1'b1;
        @(negedge clk);
        check("R5", "rdata during hot", bus_rdata, 8'h00);
        bus_addr = 3'd3;
        @(negedge clk);
        bus_wr = 1'b0;
        rst_hot_n = 1'b1;
        bus_read(3'd1, rv); check("R5", "dir kept", rv, 8'hA5);
        bus_read(3'd3, rv); check("R5", "fx kept", rv, 8'h5C);

        // R6: both resets together give cold values
        @(negedge clk);
        rst_cold_n = 1'b0; rst_hot_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_cold_n = 1'b1; rst_hot_n = 1'b1;
        bus_read(3'd1, rv); check("R6", "dir after both", rv, 8'h00);
        bus_read(3'd3, rv); check("R6", "fx after both", rv, 8'h03);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule